// File: doc/BRIEF.md
# Per-Channel Justification and Parity Event Counter Bank

This block keeps statistics counters for a set of time channels. Each channel owns four counters. Three count justification requests: positive, negative and neutral. The fourth counts overhead parity errors. Events arrive as one strobe per event type, and each strobe carries the channel ID it applies to. In a single cycle each event type can hit one channel, so up to four counters advance together.

Counters saturate instead of wrapping. A mode input selects how software sees them:

- **Read-and-clear mode:** a read returns the live count and restarts that counter from zero in the same cycle.
- **Periodic snapshot mode:** a sync pulse copies every live count into a holding register and zeroes the live counts. Reads then return the held values and have no side effect.

Read data comes back on a registered port one cycle after the read strobe.

Top module: `evcnt_bank`

## Requirements
- R1: Each channel has four independent counters, addressed as read address = channel*4 + type, with type 0 = positive justification, 1 = negative justification, 2 = neutral justification, 3 = parity error. An event strobe of a given type raises only the counter of its tagged channel and type.
- R2: Strobes of different types asserted in the same cycle are all counted, whether they name the same channel or different channels.
- R3: A 16-bit counter that reaches 0xFFFF stays at 0xFFFF while further events arrive.
- R4: With the mode input low (read-and-clear), a read returns the count accumulated so far and resets that counter, so an immediate second read with no events in between returns 0.
- R5: In read-and-clear mode, an event for the addressed counter in the same cycle as its read is not lost: the read returns the prior count and the next read returns 1.
- R6: With the mode input high (periodic), a sync pulse moves every live count into its holding register and zeroes the live count. An event in the sync cycle becomes the first count of the new interval.
- R7: In periodic mode a read returns the holding register as it stood before that clock edge and changes no counter, so repeated reads with no sync in between return the same value.
- R8: A read strobe in cycle N produces rdValid high and the read data in cycle N+1. rdValid is low in any cycle that does not follow a read strobe.
- R9: After reset every live and held count is zero and rdValid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtValid | input | 4 | Event strobe per type (bit 0 positive, 1 negative, 2 neutral, 3 parity) |
| evtChan | input | 4*CH_W | Channel ID per type, type t in bits [t*CH_W +: CH_W] |
| modeAuto | input | 1 | 0 = read-and-clear, 1 = periodic snapshot |
| syncPulse | input | 1 | Periodic snapshot strobe, used when modeAuto is 1 |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | CH_W+2 | Counter select, channel*4 + type |
| rdData | output | CNT_W | Read data, registered |
| rdValid | output | 1 | High for one cycle, the cycle after rdEn |

## Verification
Every counter effect is due at the first clock edge after its strobe, and every read result is due at the edge after rdEn. The bench drives all inputs on the falling edge and samples rdData and rdValid on the next falling edge, half a cycle after the edge that registered them. A count is judged only through a later read, never through internal state. Coincident cases, an event in the read cycle and an event in the sync cycle, are driven on the same falling edge as the read or sync. Their effect is then checked by a second read one cycle later.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  localparam int NUM_TYPES = 4;
  localparam int TYPE_W    = 2;

  typedef enum logic [TYPE_W-1:0] {
    EV_POS = 2'd0,
    EV_NEG = 2'd1,
    EV_NEU = 2'd2,
    EV_PAR = 2'd3
  } evType_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic snap;     // copy live into hold, clear live
    logic rdClr;    // clear the addressed live counter
    logic rdLoad;   // register read data
    logic selHold;  // read from hold bank
  } cntStb_t;
endpackage

// File: rtl/evcnt_ctrl.sv
module evcnt_ctrl
  import evcnt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2,
  localparam int NCNT  = NUM_CH * NUM_TYPES
) (
  input  logic [NUM_TYPES-1:0]      evtValid,
  input  logic [NUM_TYPES*CH_W-1:0] evtChan,
  input  logic                      modeAuto,
  input  logic                      syncPulse,
  input  logic                      rdEn,
  output logic [NCNT-1:0]           incVec,
  output cntStb_t                   stb
);
  // Decode each (channel, type) pair into a per-counter increment
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar t = 0; t < NUM_TYPES; t++) begin : g_ty
      assign incVec[c*NUM_TYPES + t] =
        evtValid[t] && (evtChan[t*CH_W +: CH_W] == CH_W'(c));
    end
  end

  always_comb begin
    stb.snap    = modeAuto && syncPulse;
    stb.rdClr   = rdEn && !modeAuto;
    stb.rdLoad  = rdEn;
    stb.selHold = modeAuto;
  end
endmodule

// File: rtl/evcnt_dp.sv
module evcnt_dp
  import evcnt_pkg::*;
#(
  parameter int NCNT   = 16,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCNT-1:0]   incVec,
  input  cntStb_t           stb,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic              rdValid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] liveCnt [NCNT];
  logic [CNT_W-1:0] holdCnt [NCNT];

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    logic             clrHere;
    logic [CNT_W-1:0] baseVal;
    logic [CNT_W-1:0] nextVal;

    always_comb begin
      clrHere = stb.snap || (stb.rdClr && (rdAddr == ADDR_W'(i)));
      baseVal = clrHere ? '0 : liveCnt[i];
      if (incVec[i] && (baseVal != CNT_MAX))
        nextVal = baseVal + CNT_W'(1);
      else
        nextVal = baseVal;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        liveCnt[i] <= '0;
        holdCnt[i] <= '0;
      end else begin
        liveCnt[i] <= nextVal;
        if (stb.snap) holdCnt[i] <= liveCnt[i];
      end
    end
  end

  logic addrOk;
  assign addrOk = ({1'b0, rdAddr} < (ADDR_W+1)'(NCNT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.rdLoad;
      if (stb.rdLoad) begin
        if (!addrOk)          rdData <= '0;
        else if (stb.selHold) rdData <= holdCnt[rdAddr];
        else                  rdData <= liveCnt[rdAddr];
      end
    end
  end
endmodule

// File: rtl/evcnt_bank.sv
module evcnt_bank
  import evcnt_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int CNT_W   = 16,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + TYPE_W,
  localparam int NCNT   = NUM_CH * NUM_TYPES
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_TYPES-1:0]      evtValid,
  input  logic [NUM_TYPES*CH_W-1:0] evtChan,
  input  logic                      modeAuto,
  input  logic                      syncPulse,
  input  logic                      rdEn,
  input  logic [ADDR_W-1:0]         rdAddr,
  output logic [CNT_W-1:0]          rdData,
  output logic                      rdValid
);
  logic [NCNT-1:0] incVec;
  cntStb_t         stb;

  evcnt_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ctrl (
    .evtValid (evtValid),
    .evtChan  (evtChan),
    .modeAuto (modeAuto),
    .syncPulse(syncPulse),
    .rdEn     (rdEn),
    .incVec   (incVec),
    .stb      (stb)
  );

  evcnt_dp #(.NCNT(NCNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .incVec (incVec),
    .stb    (stb),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .rdValid(rdValid)
  );
endmodule

// File: rtl/evcnt_chk.sv
module evcnt_chk #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              modeAuto,
  input logic              syncPulse,
  input logic [CNT_W-1:0]  rdData,
  input logic              rdValid
);
  // R8: a read strobe yields rdValid on the next cycle
  assert_rd_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  // R8: no rdValid without a preceding strobe
  assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

  // R8: read data moves only together with rdValid
  assert_data_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> $stable(rdData));

  // R7: periodic mode, back-to-back reads of one address with no sync agree
  assert_hold_reads_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeAuto && rdEn && !syncPulse)
      ##1 (modeAuto && rdEn && $stable(rdAddr)) |=> $stable(rdData));
endmodule

bind evcnt_bank evcnt_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rdEn     (rdEn),
  .rdAddr   (rdAddr),
  .modeAuto (modeAuto),
  .syncPulse(syncPulse),
  .rdData   (rdData),
  .rdValid  (rdValid)
);

// File: tb/evcnt_bank_tb.sv
module evcnt_bank_tb;
  localparam int NUM_CH = 4;
  localparam int CH_W   = 2;
  localparam int CNT_W  = 16;
  localparam int NCNT   = NUM_CH * 4;
  localparam int NVEC   = 6;

  // Vector: {type mask[3:0], per-type channel[7:0] (type t at bits t*2+:2), repeat count[7:0]}
  localparam logic [19:0] VEC [NVEC] = '{
    {4'b0001, 8'b00_00_00_00, 8'd3},
    {4'b1111, 8'b11_10_01_00, 8'd5},
    {4'b0110, 8'b00_11_11_00, 8'd2},
    {4'b1000, 8'b01_00_00_00, 8'd7},
    {4'b0101, 8'b00_10_00_10, 8'd4},
    {4'b0010, 8'b00_00_00_00, 8'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] evtValid = '0;
  logic [4*CH_W-1:0] evtChan = '0;
  logic modeAuto = 1'b0;
  logic syncPulse = 1'b0;
  logic rdEn = 1'b0;
  logic [CH_W+1:0] rdAddr = '0;
  logic [CNT_W-1:0] rdData;
  logic rdValid;

  int nTests = 0;
  int nFail  = 0;
  int model [NCNT];
  bit finished = 0;

  always #2.5 clk = ~clk;

  evcnt_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtChan(evtChan),
    .modeAuto(modeAuto), .syncPulse(syncPulse), .rdEn(rdEn),
    .rdAddr(rdAddr), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic applyEvt(input logic [3:0] mask, input logic [7:0] chans, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      evtValid = mask;
      evtChan  = chans;
    end
    @(negedge clk);
    evtValid = '0;
  endtask

  task automatic doRead(input int addr, input int exp, input string req);
    @(negedge clk);
    rdEn   = 1'b1;
    rdAddr = (CH_W+2)'(addr);
    @(negedge clk);
    rdEn = 1'b0;
    check(rdValid === 1'b1, "R8 valid", int'(rdValid), 1);
    check(rdData == CNT_W'(exp), req, int'(rdData), exp);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCNT; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9: reset state
    check(rdValid === 1'b0, "R9 rdValid after reset", int'(rdValid), 0);
    doRead(0, 0, "R9 live zero");
    doRead(15, 0, "R9 live zero");
    @(negedge clk);
    check(rdValid === 1'b0, "R8 valid drops", int'(rdValid), 0);

    // R1/R2: table of event patterns, read-and-clear mode
    for (int v = 0; v < NVEC; v++) begin
      applyEvt(VEC[v][19:16], VEC[v][15:8], int'(VEC[v][7:0]));
      for (int t = 0; t < 4; t++)
        if (VEC[v][16+t]) model[int'(VEC[v][8+2*t +: 2])*4 + t] += int'(VEC[v][7:0]);
    end
    for (int a = 0; a < NCNT; a++) begin
      doRead(a, model[a], "R1 R2 count per channel and type");
      model[a] = 0;
    end
    // R4: cleared by the read
    doRead(1, 0, "R4 cleared after read");
    doRead(4, 0, "R4 cleared after read");

    // R5: event coincident with read of same counter (ch2, neutral -> addr 10)
    applyEvt(4'b0100, 8'b00_10_00_00, 6);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = 4'd10;
    evtValid = 4'b0100; evtChan = 8'b00_10_00_00;
    @(negedge clk);
    rdEn = 1'b0; evtValid = '0;
    check(rdData == 16'd6, "R5 prior count returned", int'(rdData), 6);
    doRead(10, 1, "R5 coincident event kept");

    // R6/R7: periodic mode
    @(negedge clk);
    modeAuto = 1'b1;
    applyEvt(4'b1000, 8'b10_00_00_00, 9);   // ch2 parity -> addr 11
    doRead(11, 0, "R7 hold before sync");
    @(negedge clk);
    syncPulse = 1'b1;
    evtValid = 4'b1000; evtChan = 8'b10_00_00_00;
    @(negedge clk);
    syncPulse = 1'b0; evtValid = '0;
    doRead(11, 9, "R6 snapshot value");
    doRead(11, 9, "R7 read has no side effect");
    doRead(11, 9, "R7 read has no side effect");
    @(negedge clk);
    syncPulse = 1'b1;
    @(negedge clk);
    syncPulse = 1'b0;
    doRead(11, 1, "R6 sync-cycle event in new interval");
    @(negedge clk);
    syncPulse = 1'b1;
    @(negedge clk);
    syncPulse = 1'b0;
    doRead(11, 0, "R6 live cleared by sync");

    // R3: saturation in read-and-clear mode (ch1 positive -> addr 4)
    @(negedge clk);
    modeAuto = 1'b0;
    applyEvt(4'b0001, 8'b00_00_00_01, 65540);
    doRead(4, 65535, "R3 saturate at 0xFFFF");
    doRead(4, 0, "R3 R4 clear after saturation");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule